// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence for a four-beat memory burst. A starting address is captured when either of two start strobes is high at a rising clock edge. After that, each cycle with the advance input high steps a 2-bit beat counter, and the low two address bits follow that counter. The upper address bits stay fixed for the whole burst.

The order of the four beats is set by a static order-select pin that is not registered. In linear order the low bits count up from the loaded value and wrap modulo four. In interleaved order the low bits are the loaded low bits XORed with the beat count. The block also outputs the beat number and a flag that is high on the final beat.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset makes `addr_out` equal 0, `burst_pos` equal 0 and `burst_last` equal 0 after the next rising edge.
- R2: When `strobe_a` or `strobe_b` (or both) is high at a rising edge, `addr_out` equals the `addr_in` sampled at that edge and `burst_pos` equals 0 once that edge has passed.
- R3: At an edge with both strobes low and `advance` low, `burst_pos` and `addr_out` keep their values, and `addr_in` has no effect.
- R4: With `order_il` = 0 (linear), each advance adds 1 modulo 4 to `addr_out[1:0]`. Starting from low bits 01, the sequence is 01,10,11,00.
- R5: With `order_il` = 1 (interleaved), `addr_out[1:0]` equals the loaded low bits XOR `burst_pos`. Starting from 01, the sequence is 01,00,11,10.
- R6: While no strobe is high, `addr_out[ADDR_W-1:2]` does not change, even while `advance` is high.
- R7: A strobe at the same edge as `advance` loads `addr_in` with `burst_pos` = 0, and the advance is ignored. A strobe in mid-burst reloads at once.
- R8: Each advance adds 1 modulo 4 to `burst_pos`. After the fourth beat, one more advance returns `addr_out` to the loaded starting address with `burst_pos` = 0.
- R9: `order_il` acts combinationally. Changing it between edges changes `addr_out[1:0]` within the same cycle and leaves `burst_pos` unchanged.
- R10: `burst_last` is 1 exactly when `burst_pos` equals 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_a | input | 1 | First burst-start strobe |
| strobe_b | input | 1 | Second burst-start strobe |
| advance | input | 1 | Step to the next beat |
| order_il | input | 1 | Order select: 0 linear, 1 interleaved (static, unregistered) |
| addr_in | input | ADDR_W | Starting address |
| addr_out | output | ADDR_W | Current burst address |
| burst_pos | output | 2 | Beat number within the burst |
| burst_last | output | 1 | High on the fourth beat |

## Verification
Loads, advances and reset all take effect through a single register stage. Their results appear after the rising edge that samples the stimulus. The bench therefore drives inputs on the falling edge and checks on the falling edge that follows the next rising edge. The order select is the exception: it reaches `addr_out` through logic only. The bench changes it between edges and checks one nanosecond later, with no clock edge in between.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int CNT_W = 2;

    typedef logic [CNT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic step;
    } beat_ctl_t;

    function automatic beat_t map_beat(beat_t base, beat_t cnt, order_e ord);
        beat_t r;
        if (ord == ORD_INTERLEAVE) r = base ^ cnt;
        else                       r = base + cnt;
        return r;
    endfunction
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q
);
    always_ff @(posedge clk) begin
        if (rst)           base_q <= '0;
        else if (ctl.load) base_q <= addr_in;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  beat_ctl_t ctl,
    output beat_t     cnt_q,
    output logic      last
);
    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (ctl.load) cnt_q <= '0;
        else if (ctl.step) cnt_q <= cnt_q + beat_t'(1);
    end

    assign last = (cnt_q == '1);
endmodule

// File: rtl/burst_beat_map.sv
module burst_beat_map
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] base,
    input  beat_t             cnt,
    input  order_e            ord,
    output logic [ADDR_W-1:0] addr
);
    localparam int UP_W = ADDR_W - CNT_W;

    generate
        if (UP_W > 0) begin : g_upper
            assign addr[ADDR_W-1:CNT_W] = base[ADDR_W-1:CNT_W];
        end
    endgenerate

    assign addr[CNT_W-1:0] = map_beat(base[CNT_W-1:0], cnt, ord);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic              advance,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [CNT_W-1:0]  burst_pos,
    output logic              burst_last
);
    beat_ctl_t         ctl;
    logic [ADDR_W-1:0] base_q;
    beat_t             cnt_q;

    assign ctl.load = strobe_a | strobe_b;
    assign ctl.step = advance;

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk(clk), .rst(rst), .ctl(ctl), .addr_in(addr_in), .base_q(base_q)
    );

    burst_beat_ctr u_ctr (
        .clk(clk), .rst(rst), .ctl(ctl), .cnt_q(cnt_q), .last(burst_last)
    );

    burst_beat_map #(.ADDR_W(ADDR_W)) u_map (
        .base(base_q), .cnt(cnt_q), .ord(order_e'(order_il)), .addr(addr_out)
    );

    assign burst_pos = cnt_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_a,
    input logic              strobe_b,
    input logic              advance,
    input logic              order_il,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        burst_pos,
    input logic              burst_last
);
    logic ld;
    assign ld = strobe_a | strobe_b;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && burst_pos == 2'd0 && !burst_last));

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
        ld |=> (addr_out == $past(addr_in) && burst_pos == 2'd0));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld && !advance) |=> $stable(burst_pos));

    assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!ld && advance && !order_il) |=>
        (!order_il -> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

    assert_interleave_rel_R5: assert property (@(posedge clk) disable iff (rst)
        (!ld && order_il) |=>
        (order_il -> (addr_out[1:0] ^ burst_pos) == $past(addr_out[1:0] ^ burst_pos)));

    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(addr_out[ADDR_W-1:2]));

    assert_pos_step_R8: assert property (@(posedge clk) disable iff (rst)
        (!ld && advance) |=> burst_pos == $past(burst_pos) + 2'd1);

    always_comb begin
        if (!rst) begin
            assert_last_flag_R10: assert (burst_last == (burst_pos == 2'd3));
        end
    end
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .advance(advance), .order_il(order_il), .addr_in(addr_in),
    .addr_out(addr_out), .burst_pos(burst_pos), .burst_last(burst_last)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int ADDR_W = 18;
    localparam int NVEC   = 16;

    typedef struct packed {
        logic              sa;
        logic              sb;
        logic              adv;
        logic              il;
        logic [ADDR_W-1:0] ain;
        logic [ADDR_W-1:0] exp_addr;
        logic [1:0]        exp_pos;
        logic [3:0]        req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 18'h12341, 18'h12341, 2'd0, 4'd2},
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h12342, 2'd1, 4'd4},
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h12343, 2'd2, 4'd4},
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h12340, 2'd3, 4'd4},
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h00000, 18'h12341, 2'd0, 4'd8},
        '{1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h12341, 2'd0, 4'd3},
        '{1'b0, 1'b1, 1'b0, 1'b1, 18'h2ABC5, 18'h2ABC5, 2'd0, 4'd2},
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 18'h2ABC4, 2'd1, 4'd5},
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 18'h2ABC7, 2'd2, 4'd5},
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 18'h2ABC6, 2'd3, 4'd5},
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 18'h2ABC5, 2'd0, 4'd8},
        '{1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 18'h2ABC4, 2'd1, 4'd5},
        '{1'b1, 1'b0, 1'b1, 1'b0, 18'h00003, 18'h00003, 2'd0, 4'd7},
        '{1'b0, 1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h00000, 2'd1, 4'd6},
        '{1'b0, 1'b0, 1'b0, 1'b0, 18'h15550, 18'h00000, 2'd1, 4'd3},
        '{1'b1, 1'b1, 1'b0, 1'b0, 18'h0F00E, 18'h0F00E, 2'd0, 4'd2}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              strobe_a, strobe_b, advance, order_il;
    logic [ADDR_W-1:0] addr_in;
    logic [ADDR_W-1:0] addr_out;
    logic [1:0]        burst_pos;
    logic              burst_last;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b),
        .advance(advance), .order_il(order_il), .addr_in(addr_in),
        .addr_out(addr_out), .burst_pos(burst_pos), .burst_last(burst_last)
    );

    task automatic check(input int r, input logic [ADDR_W-1:0] ea, input logic [1:0] ep);
        logic el;
        el = (ep == 2'd3);
        checks++;
        if (addr_out !== ea || burst_pos !== ep || burst_last !== el) begin
            errors++;
            $display("FAIL R%0d addr=%h pos=%0d last=%b expected addr=%h pos=%0d last=%b",
                     r, addr_out, burst_pos, burst_last, ea, ep, el);
        end
    endtask

    task automatic step(input logic sa, input logic sb, input logic adv, input logic il,
                        input logic [ADDR_W-1:0] a);
        strobe_a = sa; strobe_b = sb; advance = adv; order_il = il; addr_in = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; strobe_a = 1'b0; strobe_b = 1'b0; advance = 1'b0;
        order_il = 1'b0; addr_in = '0;
        @(posedge clk);
        @(negedge clk);
        check(1, '0, 2'd0);   // R1 reset state
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].sa, VECS[i].sb, VECS[i].adv, VECS[i].il, VECS[i].ain);
            check(int'(VECS[i].req), VECS[i].exp_addr, VECS[i].exp_pos);
            if (VECS[i].req == 4'd4 && VECS[i].exp_pos == 2'd3) check(10, VECS[i].exp_addr, 2'd3); // R10
        end

        // R9: order select acts without a clock edge (base low 11, pos 1)
        step(1'b1, 1'b0, 1'b0, 1'b0, 18'h00003);
        step(1'b0, 1'b0, 1'b1, 1'b0, 18'h00000);
        check(9, 18'h00000, 2'd1);
        order_il = 1'b1;
        #1;
        check(9, 18'h00002, 2'd1);
        order_il = 1'b0;
        #1;
        check(9, 18'h00000, 2'd1);

        // R7: mid-burst reload from the second strobe together with advance
        @(negedge clk);
        step(1'b0, 1'b1, 1'b1, 1'b0, 18'h3FFFE);
        check(7, 18'h3FFFE, 2'd0);
        step(1'b0, 1'b0, 1'b1, 1'b0, 18'h00000);
        step(1'b0, 1'b0, 1'b1, 1'b0, 18'h00000);
        step(1'b0, 1'b0, 1'b1, 1'b0, 18'h00000);
        check(10, 18'h3FFFD, 2'd3);   // R10 last beat, linear wrap

        // R1: reset in mid-burst
        rst = 1'b1;
        step(1'b0, 1'b0, 1'b1, 1'b0, 18'h00000);
        check(1, '0, 2'd0);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule